// File: doc/BRIEF.md
# Two-Wire Tuner Control Receiver

This block is a receive-only slave on a two-wire serial bus (SCL clock line, SDA data line). It holds the two control words of a radio tuner: a 7-bit channel code and a 7-bit test-mode code. Both bus lines are sampled by the fast system clock through synchronizers. Start and stop conditions are found from the sampled edges. Bytes are shifted in MSB first. After every byte that belongs to an addressed frame, the slave pulls SDA low for the ninth clock.

After the write address, the most significant bit of each data byte is a routing tag and the other seven bits are the payload. A tag of 1 selects the channel word and a tag of 0 selects the test-mode word. One frame can therefore update either word alone, or both words in turn. Each update of a word raises a one-cycle strobe.

The update strobes are plain pulses with no ready input and no back-pressure: a strobe is a single-cycle event and the new value stays on the register output until it is overwritten. SDA is modelled as open-drain: `sda_oe` high means the pad pulls the line low.

Top module: `tuner_ctrl_slave`

## Requirements
- R1: After reset, `chan_q` is 1000101 and `test_q` is 0000000, `sda_oe` is low and both strobes are low.
- R2: SDA falling while SCL is high opens a frame (start), and SDA rising while SCL is high closes it (stop). Any start or stop releases SDA in the following cycle. SCL pulses that arrive after a stop and before the next start change nothing.
- R3: A first byte equal to 1100000 followed by a write bit of 0 is acknowledged: `sda_oe` is high during the ninth SCL high phase.
- R4: A first byte that differs from 1100000 followed by 0 (this includes the same address with a read bit of 1) gets no acknowledge. Every later bit is then ignored until the next start: no acknowledge is given and neither word changes.
- R5: A data byte whose bit 7 is 1 loads its bits 6..0 into `chan_q` and pulses `chan_upd` for one cycle. `chan_q` changes in no other case.
- R6: A data byte whose bit 7 is 0 loads its bits 6..0 into `test_q` and pulses `test_upd` for one cycle. `test_q` changes in no other case.
- R7: In a frame with several data bytes, each byte is acknowledged and routed by its own tag, in arrival order. The usual form is a channel byte (tag 1) followed by a test byte (tag 0).
- R8: A frame with a single data byte updates only the word that its tag selects.
- R9: A start or stop that arrives before the eighth bit of a byte aborts that byte and leaves both words unchanged.
- R10: `sda_oe` rises only in the cycle after a detected SCL falling edge, about three system clocks after the pin changes. It falls after the next SCL falling edge.
- R11: Each update strobe lasts exactly one cycle, and the two strobes are never high together.
- R12: Bus activity before the first start after reset is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| chan_q | output | 7 | Channel code word |
| test_q | output | 7 | Test-mode code word |
| chan_upd | output | 1 | One-cycle pulse when chan_q is loaded |
| test_upd | output | 1 | One-cycle pulse when test_q is loaded |

## Verification
The eighth SCL rising edge of a data byte does two things in the same cycle: it commits the word with its strobe, and it arms the acknowledge that starts on the next falling edge. A wrong decision in that cycle shows up either as a wrong word or as a missing drive on SDA. The bench sends frames with one, two and three data bytes and alternating tags. A behavioural model predicts, cycle by cycle, the register values, the strobes and `sda_oe`, and these are compared at every falling clock edge. Frames aborted mid-byte, wrong addresses and read addresses check that neither action happens.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_SKIP
  } tcs_state_e;
endpackage

// File: rtl/tcs_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous lines; resets to
// the idle (high) bus level so no false condition is seen after reset.
module tcs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '1;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/tcs_cond.sv
// Edge and bus-condition detector on synchronized lines (R2).
module tcs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tcs_shift.sv
// MSB-first byte assembler with bit counter; flags the sample that
// completes a byte and presents the full byte combinationally.
module tcs_shift #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sample,
  input  logic          bit_in,
  output logic          byte_done,
  output logic [BW-1:0] byte_full
);
  localparam int CW = $clog2(BW);

  logic [BW-2:0] sreg;
  logic [CW-1:0] cnt;

  assign byte_done = sample && (cnt == CW'(BW - 1));
  assign byte_full = {sreg, bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (clear) begin
      cnt  <= '0;
    end else if (sample) begin
      sreg <= {sreg[BW-3:0], bit_in};
      cnt  <= byte_done ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/tcs_regs.sv
// Tag-routed control words with presets and one-cycle load strobes
// (R1, R5, R6, R11).
module tcs_regs #(
  parameter int          DW          = 7,
  parameter logic [DW-1:0] CHAN_PRESET = '0,
  parameter logic [DW-1:0] TEST_PRESET = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          tag,
  input  logic [DW-1:0] payload,
  output logic [DW-1:0] chan_q,
  output logic [DW-1:0] test_q,
  output logic          chan_upd,
  output logic          test_upd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q   <= CHAN_PRESET;
      test_q   <= TEST_PRESET;
      chan_upd <= 1'b0;
      test_upd <= 1'b0;
    end else begin
      chan_upd <= commit & tag;
      test_upd <= commit & ~tag;
      if (commit && tag)  chan_q <= payload;
      if (commit && !tag) test_q <= payload;
    end
  end
endmodule

// File: rtl/tuner_ctrl_slave.sv
module tuner_ctrl_slave
  import tcs_pkg::*;
#(
  parameter int            DW          = 7,
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-1:0] DEV_ADDR    = DW'(7'b1100000),
  parameter logic [DW-1:0] CHAN_PRESET = DW'(7'b1000101),
  parameter logic [DW-1:0] TEST_PRESET = DW'(7'b0000000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [DW-1:0] chan_q,
  output logic [DW-1:0] test_q,
  output logic          chan_upd,
  output logic          test_upd
);
  localparam int BW = DW + 1;
  localparam logic [BW-1:0] WR_MATCH = {DEV_ADDR, 1'b0};

  tcs_state_e    state;
  logic          ack_pend;
  logic [1:0]    raw_lines, sync_lines;
  logic          scl_rise, scl_fall, start_det, stop_det;
  logic          sample, byte_done, commit, in_skip;
  logic [BW-1:0] byte_full;

  assign raw_lines = {scl_i, sda_i};

  tcs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
  );

  tcs_cond u_cond (
    .clk(clk), .rst_n(rst_n),
    .scl_s(sync_lines[1]), .sda_s(sync_lines[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // Bits are taken only while a byte of an open frame is expected (R12).
  assign sample = scl_rise && (state == ST_ADDR || state == ST_DATA)
                  && !start_det && !stop_det;

  tcs_shift #(.BW(BW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .clear(start_det | stop_det),
    .sample(sample), .bit_in(sync_lines[0]),
    .byte_done(byte_done), .byte_full(byte_full)
  );

  // A data byte commits on its eighth sample; partial bytes never do (R9).
  assign commit  = byte_done && (state == ST_DATA);
  assign in_skip = (state == ST_SKIP);

  tcs_regs #(.DW(DW), .CHAN_PRESET(CHAN_PRESET), .TEST_PRESET(TEST_PRESET)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .tag(byte_full[BW-1]), .payload(byte_full[DW-1:0]),
    .chan_q(chan_q), .test_q(test_q),
    .chan_upd(chan_upd), .test_upd(test_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ack_pend <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      ack_pend <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      ack_pend <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (byte_done) begin
            if (byte_full == WR_MATCH) begin
              state    <= ST_ACK;   // R3
              ack_pend <= 1'b1;
            end else begin
              state    <= ST_SKIP;  // R4
            end
          end
        end
        ST_DATA: begin
          if (byte_done) begin
            state    <= ST_ACK;     // R7
            ack_pend <= 1'b1;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (ack_pend) begin
              sda_oe   <= 1'b1;     // R10: ninth clock begins
              ack_pend <= 1'b0;
            end else begin
              sda_oe   <= 1'b0;
              state    <= ST_DATA;
            end
          end
        end
        default: ;                  // ST_IDLE, ST_SKIP wait for a start
      endcase
    end
  end
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
  parameter int DW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_fall,
  input logic          start_det,
  input logic          stop_det,
  input logic          in_skip,
  input logic          sda_oe,
  input logic [DW-1:0] chan_q,
  input logic [DW-1:0] test_q,
  input logic          chan_upd,
  input logic          test_upd
);
  p_cond_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_oe);

  p_skip_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> !sda_oe);

  p_chan_only_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_q) |-> chan_upd);

  p_test_only_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(test_q) |-> test_upd);

  p_ack_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  p_ack_end_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  p_strobe_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(chan_upd && test_upd));

  p_chan_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    chan_upd |=> !chan_upd);

  p_test_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    test_upd |=> !test_upd);
endmodule

bind tuner_ctrl_slave tcs_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .in_skip(in_skip), .sda_oe(sda_oe),
  .chan_q(chan_q), .test_q(test_q), .chan_upd(chan_upd), .test_upd(test_upd)
);

// File: tb/tuner_ctrl_slave_test.sv
module tuner_ctrl_slave_test;
  localparam int HALF = 8;
  localparam int LAT  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, chan_upd, test_upd;
  logic [6:0] chan_q, test_q;
  logic sda_bus;

  always #2 clk = ~clk;   // 250 MHz

  assign sda_bus = sda_m & ~sda_oe;

  tuner_ctrl_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .chan_q(chan_q), .test_q(test_q),
    .chan_upd(chan_upd), .test_upd(test_upd)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit run  = 0;

  // Behavioural reference model
  typedef enum int {M_IDLE, M_ADDR, M_DATA, M_SKIP} mstate_t;
  mstate_t mst = M_IDLE;
  bit [6:0] exp_chan = 7'b1000101;
  bit [6:0] exp_test = 7'b0000000;
  bit exp_cu = 0, exp_tu = 0, exp_oe = 0, m_ack = 0;

  task automatic check_val(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    #1;
    if (run && !done) begin
      check_val("R5", "chan_q", chan_q, exp_chan);
      check_val("R6", "test_q", test_q, exp_test);
      check_val("R11", "chan_upd", chan_upd, exp_cu);
      check_val("R11", "test_upd", test_upd, exp_tu);
      check_val("R10", "sda_oe", sda_oe, exp_oe);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_byte(input bit [7:0] v);
    m_ack = 0;
    case (mst)
      M_ADDR: if (v == 8'hC0) begin mst = M_DATA; m_ack = 1; end
              else mst = M_SKIP;
      M_DATA: begin
        m_ack = 1;
        if (v[7]) begin exp_chan = v[6:0]; exp_cu = 1; end
        else      begin exp_test = v[6:0]; exp_tu = 1; end
      end
      default: ;
    endcase
  endtask

  // Sends n leading bits of v; a full byte also plays the ninth clock.
  task automatic send_bits(input bit [7:0] v, input int n, input string req);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); sda_m = v[i];
      wait_n(HALF);
      scl_m = 1;
      wait_n(LAT);
      if (i == 0) model_byte(v);
      wait_n(1);
      exp_cu = 0; exp_tu = 0;
      wait_n(HALF - LAT - 1);
      scl_m = 0;
    end
    if (n == 8) begin
      sda_m = 1;
      if (m_ack) begin wait_n(LAT); exp_oe = 1; wait_n(HALF - LAT); end
      else wait_n(HALF);
      scl_m = 1;
      wait_n(HALF / 2);
      check_val(req, "ack on SDA", !sda_bus, m_ack);
      wait_n(HALF / 2);
      scl_m = 0;
      if (m_ack) begin wait_n(LAT); exp_oe = 0; wait_n(HALF - LAT); end
      else wait_n(HALF);
    end
  endtask

  task automatic send_byte(input bit [7:0] v, input string req);
    send_bits(v, 8, req);
  endtask

  task automatic do_start();
    @(negedge clk); sda_m = 1;
    wait_n(HALF); scl_m = 1;
    wait_n(HALF); sda_m = 0;
    wait_n(LAT); mst = M_ADDR; exp_oe = 0;
    wait_n(HALF - LAT); scl_m = 0;
    wait_n(HALF);
  endtask

  task automatic do_stop();
    @(negedge clk); sda_m = 0;
    wait_n(HALF); scl_m = 1;
    wait_n(HALF); sda_m = 1;
    wait_n(LAT); mst = M_IDLE; exp_oe = 0;
    wait_n(HALF);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    wait_n(5);
    rst_n = 1;
    wait_n(2);
    // R1: presets after reset
    check_val("R1", "chan preset", chan_q, 7'b1000101);
    check_val("R1", "test preset", test_q, 7'b0000000);
    check_val("R1", "sda_oe idle", sda_oe, 0);
    check_val("R1", "strobes idle", {chan_upd, test_upd}, 0);
    run = 1;

    // R12: bytes clocked before any start are ignored
    @(negedge clk); scl_m = 0; wait_n(HALF);
    send_byte(8'hC0, "R12");
    send_byte(8'h81, "R12");
    check_val("R12", "chan untouched", chan_q, 7'b1000101);
    do_stop();

    // R7 normal frame: channel then test, R3 address ack
    do_start();
    send_byte(8'hC0, "R3");
    send_byte(8'h9D, "R7");
    send_byte(8'h01, "R7");
    do_stop();
    check_val("R7", "chan after frame", chan_q, 7'h1D);
    check_val("R7", "test after frame", test_q, 7'h01);

    // R8 single-byte frames, each tag
    do_start(); send_byte(8'hC0, "R3"); send_byte(8'h05, "R8"); do_stop();
    check_val("R8", "test only", test_q, 7'h05);
    check_val("R8", "chan kept", chan_q, 7'h1D);
    do_start(); send_byte(8'hC0, "R3"); send_byte(8'hEE, "R8"); do_stop();
    check_val("R8", "chan only", chan_q, 7'h6E);
    check_val("R8", "test kept", test_q, 7'h05);

    // R4 wrong address, then read bit on the right address
    do_start(); send_byte(8'hA0, "R4"); send_byte(8'h81, "R4"); do_stop();
    check_val("R4", "chan after bad addr", chan_q, 7'h6E);
    do_start(); send_byte(8'hC1, "R4"); send_byte(8'h10, "R4"); do_stop();
    check_val("R4", "test after read addr", test_q, 7'h05);

    // R9 repeated start mid byte, then a valid byte (R2)
    do_start(); send_byte(8'hC0, "R3");
    send_bits(8'h90, 5, "R9");
    do_start();
    check_val("R9", "chan after aborted byte", chan_q, 7'h6E);
    send_byte(8'hC0, "R2"); send_byte(8'h83, "R2");
    do_stop();
    check_val("R2", "chan after restart", chan_q, 7'h03);

    // R9 stop mid byte; R2 bits after stop ignored
    do_start(); send_byte(8'hC0, "R3");
    send_bits(8'h20, 4, "R9");
    do_stop();
    check_val("R9", "test after stop abort", test_q, 7'h05);
    @(negedge clk); scl_m = 0; wait_n(HALF);
    send_byte(8'h7F, "R2");
    check_val("R2", "test after idle bits", test_q, 7'h05);

    // R7 three data bytes with alternating tags
    do_start(); send_byte(8'hC0, "R3");
    send_byte(8'h2A, "R7"); send_byte(8'hC5, "R7"); send_byte(8'h33, "R7");
    do_stop();
    check_val("R7", "test after three", test_q, 7'h33);
    check_val("R7", "chan after three", chan_q, 7'h45);

    wait_n(4);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule